// File: doc/BRIEF.md
# Latency-Shaping Memory Responder

This block sits at the memory end of a read/write request path that moves 16 bytes per beat. It behaves as a deliberately slow memory. Each request carries one beat. A read returns its word a programmable number of cycles after it was accepted. A write is acknowledged a programmable number of cycles after its beat was taken. Because a write has only one beat, that beat is also its last. The words live in a small internal array.

Three things hold back traffic. The first is a cap on outstanding reads. The second is a cap on outstanding writes. The third is a cap on the sum of the two. On top of these caps, a bandwidth throttle splits time into windows of a programmable number of cycles. Within each window it lets through only a set percentage of the cycles as data beats. The suggested settings are:

- read latency 180
- write latency 30
- all three caps 128
- bandwidth 50 percent
- window 100 cycles

Pending reads and pending writes each wait in a queue ordered by acceptance. Each entry carries its due time, and the head entry is compared against a free-running cycle counter. The configuration inputs must stay unchanged while any transaction is outstanding.

Top module: `slow_mem_responder`

## Requirements
- R1: A read accepted at clock edge a puts `rd_valid` high for exactly one cycle, in the cycle that follows edge a+L. L is the effective read latency. Reads return in acceptance order.
- R2: A write accepted at edge a puts `wr_ack` high for exactly one cycle, in the cycle that follows edge a+Lw. Lw is the effective write latency. In that same cycle `wr_ack_addr` holds the written word address.
- R3: `rd_data` holds the word as it stood when the read was accepted. That word comes from the most recent earlier accepted write to the same address, or is zero if the address was never written.
- R4: The effective latency is the configured value, with two exceptions. A configured 0 acts as 1. A value above 1000 acts as 1000. This applies to reads and writes alike.
- R5: No read is accepted while the outstanding read count is at least min(`cfg_rd_cap`, 128). A read counts as outstanding from its acceptance edge until the edge after which its data appears.
- R6: No write is accepted while the outstanding write count is at least min(`cfg_wr_cap`, 128). A write counts as outstanding until its acknowledge appears.
- R7: No request is accepted while the outstanding reads plus outstanding writes are at least `cfg_tot_cap`.
- R8: The throttle runs windows of W cycles back to back, with the first window starting at reset release. Within one window, at most floor(P*W/100) requests are accepted. The count of accepted requests clears at the end of each window.
- R9: A `cfg_bw_pct` above 100 acts as 100. A `cfg_bw_win` of 0 acts as 1. A percentage of 0 blocks every request.
- R10: During reset `rd_valid` and `wr_ack` are low and `rd_data` is zero. After reset the array reads as zero and `req_ready` is high when all caps are non-zero.
- R11: `req_ready` is high in every cycle in which the throttle and the caps that apply to the presented `req_write` all allow a request, whether or not `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_lat | input | 11 | Read latency in cycles |
| cfg_wr_lat | input | 11 | Write acknowledge latency in cycles |
| cfg_rd_cap | input | 8 | Outstanding read cap |
| cfg_wr_cap | input | 8 | Outstanding write cap |
| cfg_tot_cap | input | 9 | Outstanding read plus write cap |
| cfg_bw_pct | input | 7 | Bandwidth percentage |
| cfg_bw_win | input | 16 | Throttle window length in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 128 | Write beat |
| rd_valid | output | 1 | Read return valid |
| rd_data | output | 128 | Read return beat |
| wr_ack | output | 1 | Write acknowledge |
| wr_ack_addr | output | 6 | Address of the acknowledged write |

## Verification
The properties assume that the configuration inputs change only while the outstanding counts are zero. A latency change with entries in flight would break the due-time order of the queues. The stimulus therefore drains every read and acknowledge before it changes any setting. Random traffic keeps the settings fixed between drains.

The properties also assume nothing about `req_valid` holding. The bench drops and raises it freely, so acceptance is judged in each cycle on its own.

// File: rtl/slowmem_pkg.sv
package slowmem_pkg;
    localparam int BEAT_BYTES = 16;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int PCT_FULL   = 100;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;
endpackage

// File: rtl/slowmem_store.sv
module slowmem_store #(
    parameter  int AW    = 6,
    parameter  int DW    = 128,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [WORDS];

    // Array is cleared by reset so unwritten words read as zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/slowmem_due_fifo.sv
module slowmem_due_fifo #(
    parameter  int DEPTH = 128,
    parameter  int TSW   = 11,
    parameter  int DW    = 128,
    localparam int PTRW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [TSW-1:0]  push_ts,
    input  logic [DW-1:0]   push_data,
    input  logic [TSW-1:0]  now,
    output logic            due,
    output logic [DW-1:0]   head_data,
    output logic [CNTW-1:0] count
);
    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [CNTW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;

    logic [TSW-1:0] ts_mem  [DEPTH];
    logic [DW-1:0]  dat_mem [DEPTH];

    // Head leaves the queue in the cycle its due time equals the counter.
    always_comb begin
        due = (s_q.cnt != '0) && (ts_mem[s_q.rp] == now);
        s_d = s_q;
        if (push) begin
            s_d.wp = s_q.wp + PTRW'(1);
        end
        if (due) begin
            s_d.rp = s_q.rp + PTRW'(1);
        end
        case ({push, due})
            2'b10:   s_d.cnt = s_q.cnt + CNTW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNTW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            ts_mem[s_q.wp]  <= push_ts;
            dat_mem[s_q.wp] <= push_data;
        end
    end

    assign head_data = dat_mem[s_q.rp];
    assign count     = s_q.cnt;
endmodule

// File: rtl/slowmem_throttle.sv
module slowmem_throttle
    import slowmem_pkg::*;
#(
    parameter  int WINW  = 16,
    parameter  int PCTW  = 7,
    localparam int PRODW = WINW + PCTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PCTW-1:0] cfg_pct,
    input  logic [WINW-1:0] cfg_win,
    input  logic            beat,
    output logic            allow,
    output logic [WINW-1:0] used,
    output logic [WINW-1:0] quota
);
    typedef struct packed {
        logic [WINW-1:0] pos;
        logic [WINW-1:0] beats;
    } thr_t;

    thr_t s_d, s_q;

    logic [PCTW-1:0]  pct_eff;
    logic [WINW-1:0]  win_eff;
    logic [PRODW-1:0] prod;

    always_comb begin
        pct_eff = (cfg_pct > PCTW'(PCT_FULL)) ? PCTW'(PCT_FULL) : cfg_pct;
        win_eff = (cfg_win == '0) ? WINW'(1) : cfg_win;
        prod    = PRODW'(pct_eff) * PRODW'(win_eff);
        quota   = WINW'(prod / PRODW'(PCT_FULL));
        allow   = s_q.beats < quota;

        s_d = s_q;
        if (s_q.pos >= win_eff - WINW'(1)) begin
            s_d.pos   = '0;
            s_d.beats = '0;
        end else begin
            s_d.pos   = s_q.pos + WINW'(1);
            s_d.beats = s_q.beats + WINW'(beat);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign used = s_q.beats;
endmodule

// File: rtl/slow_mem_responder.sv
module slow_mem_responder
    import slowmem_pkg::*;
#(
    parameter  int ADDR_W     = 6,
    parameter  int OUTS_DEPTH = 128,
    parameter  int MAX_LAT    = 1000,
    parameter  int LAT_W      = 11,
    parameter  int WIN_W      = 16,
    parameter  int PCT_W      = 7,
    localparam int CNT_W      = $clog2(OUTS_DEPTH + 1),
    localparam int TOT_W      = CNT_W + 1,
    localparam int TS_W       = $clog2(MAX_LAT + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_rd_lat,
    input  logic [LAT_W-1:0]  cfg_wr_lat,
    input  logic [CNT_W-1:0]  cfg_rd_cap,
    input  logic [CNT_W-1:0]  cfg_wr_cap,
    input  logic [TOT_W-1:0]  cfg_tot_cap,
    input  logic [PCT_W-1:0]  cfg_bw_pct,
    input  logic [WIN_W-1:0]  cfg_bw_win,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_data,
    output logic              wr_ack,
    output logic [ADDR_W-1:0] wr_ack_addr
);
    typedef struct packed {
        logic [TS_W-1:0]   now;
        logic              rd_valid;
        logic [BEAT_W-1:0] rd_data;
        logic              wr_ack;
        logic [ADDR_W-1:0] wr_addr;
    } resp_t;

    resp_t s_d, s_q;

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] v);
        if (v == '0) begin
            return LAT_W'(1);
        end
        if (v > LAT_W'(MAX_LAT)) begin
            return LAT_W'(MAX_LAT);
        end
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cap(input logic [CNT_W-1:0] v);
        return (v > CNT_W'(OUTS_DEPTH)) ? CNT_W'(OUTS_DEPTH) : v;
    endfunction

    op_e               op;
    logic              acc_rd, acc_wr;
    logic              rd_ok, wr_ok, tot_ok;
    logic [CNT_W-1:0]  rd_cnt, wr_cnt;
    logic [TOT_W-1:0]  total;
    logic [TS_W-1:0]   rd_ts, wr_ts;
    logic              thr_allow;
    logic [WIN_W-1:0]  thr_used, thr_quota;
    logic [BEAT_W-1:0] store_rdata, rd_head;
    logic [ADDR_W-1:0] wr_head;
    logic              rd_due, wr_due;

    always_comb begin
        op     = op_e'(req_write);
        total  = TOT_W'(rd_cnt) + TOT_W'(wr_cnt);
        rd_ok  = rd_cnt < clamp_cap(cfg_rd_cap);
        wr_ok  = wr_cnt < clamp_cap(cfg_wr_cap);
        tot_ok = total < cfg_tot_cap;

        req_ready = thr_allow && tot_ok && ((op == OP_WRITE) ? wr_ok : rd_ok);
        acc_rd    = req_valid && req_ready && (op == OP_READ);
        acc_wr    = req_valid && req_ready && (op == OP_WRITE);

        rd_ts = s_q.now + TS_W'(clamp_lat(cfg_rd_lat));
        wr_ts = s_q.now + TS_W'(clamp_lat(cfg_wr_lat));

        s_d          = s_q;
        s_d.now      = s_q.now + TS_W'(1);
        s_d.rd_valid = rd_due;
        s_d.wr_ack   = wr_due;
        if (rd_due) begin
            s_d.rd_data = rd_head;
        end
        if (wr_due) begin
            s_d.wr_addr = wr_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    slowmem_store #(.AW(ADDR_W), .DW(BEAT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_wr),
        .waddr (req_addr),
        .wdata (req_wdata),
        .raddr (req_addr),
        .rdata (store_rdata)
    );

    slowmem_due_fifo #(.DEPTH(OUTS_DEPTH), .TSW(TS_W), .DW(BEAT_W)) u_rd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc_rd),
        .push_ts   (rd_ts),
        .push_data (store_rdata),
        .now       (s_q.now),
        .due       (rd_due),
        .head_data (rd_head),
        .count     (rd_cnt)
    );

    slowmem_due_fifo #(.DEPTH(OUTS_DEPTH), .TSW(TS_W), .DW(ADDR_W)) u_wr_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc_wr),
        .push_ts   (wr_ts),
        .push_data (req_addr),
        .now       (s_q.now),
        .due       (wr_due),
        .head_data (wr_head),
        .count     (wr_cnt)
    );

    slowmem_throttle #(.WINW(WIN_W), .PCTW(PCT_W)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_pct (cfg_bw_pct),
        .cfg_win (cfg_bw_win),
        .beat    (acc_rd || acc_wr),
        .allow   (thr_allow),
        .used    (thr_used),
        .quota   (thr_quota)
    );

    assign rd_valid    = s_q.rd_valid;
    assign rd_data     = s_q.rd_data;
    assign wr_ack      = s_q.wr_ack;
    assign wr_ack_addr = s_q.wr_addr;
endmodule

// File: rtl/slowmem_checker.sv
module slowmem_checker #(
    parameter int CNT_W = 8,
    parameter int TOT_W = 9,
    parameter int WIN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             rd_valid,
    input logic             wr_ack,
    input logic [CNT_W-1:0] cfg_rd_cap,
    input logic [CNT_W-1:0] cfg_wr_cap,
    input logic [TOT_W-1:0] cfg_tot_cap,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [CNT_W-1:0] wr_cnt,
    input logic [WIN_W-1:0] thr_used,
    input logic [WIN_W-1:0] thr_quota
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_rd_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |-> (rd_cnt < cfg_rd_cap));

    assert_wr_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |-> (wr_cnt < cfg_wr_cap));

    assert_total_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ((TOT_W'(rd_cnt) + TOT_W'(wr_cnt)) < cfg_tot_cap));

    assert_quota_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (thr_used < thr_quota));

    assert_rd_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_cnt) != '0));

    assert_wr_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> ($past(wr_cnt) != '0));
endmodule

bind slow_mem_responder slowmem_checker #(
    .CNT_W (CNT_W),
    .TOT_W (TOT_W),
    .WIN_W (WIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .rd_valid    (rd_valid),
    .wr_ack      (wr_ack),
    .cfg_rd_cap  (cfg_rd_cap),
    .cfg_wr_cap  (cfg_wr_cap),
    .cfg_tot_cap (cfg_tot_cap),
    .rd_cnt      (rd_cnt),
    .wr_cnt      (wr_cnt),
    .thr_used    (thr_used),
    .thr_quota   (thr_quota)
);

// File: tb/slow_mem_responder_tb.sv
module slow_mem_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 128;
    localparam int DEPTH = 128;
    localparam int MAXL  = 1000;
    localparam int LATW  = 11;
    localparam int WINW  = 16;
    localparam int PCTW  = 7;
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int TOTW  = CNTW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [LATW-1:0] cfg_rd_lat, cfg_wr_lat;
    logic [CNTW-1:0] cfg_rd_cap, cfg_wr_cap;
    logic [TOTW-1:0] cfg_tot_cap;
    logic [PCTW-1:0] cfg_bw_pct;
    logic [WINW-1:0] cfg_bw_win;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            rd_valid;
    logic [DW-1:0]   rd_data;
    logic            wr_ack;
    logic [AW-1:0]   wr_ack_addr;

    slow_mem_responder u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_rd_lat (cfg_rd_lat), .cfg_wr_lat (cfg_wr_lat),
        .cfg_rd_cap (cfg_rd_cap), .cfg_wr_cap (cfg_wr_cap),
        .cfg_tot_cap (cfg_tot_cap), .cfg_bw_pct (cfg_bw_pct), .cfg_bw_win (cfg_bw_win),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .wr_ack (wr_ack), .wr_ack_addr (wr_ack_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit mon_en   = 1'b0;
    string lat_tag = "R1";
    string thr_tag = "R8";

    logic [DW-1:0] mem_m [1 << AW];
    int            rq_due [$];
    logic [DW-1:0] rq_data [$];
    int            wq_due [$];
    logic [AW-1:0] wq_addr [$];
    int m_pos   = 0;
    int m_beats = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int eff_lat(input int v);
        if (v < 1) return 1;
        if (v > MAXL) return MAXL;
        return v;
    endfunction

    function automatic int eff_cap(input int v);
        return (v > DEPTH) ? DEPTH : v;
    endfunction

    function automatic int exp_quota();
        int p;
        int w;
        p = (int'(cfg_bw_pct) > 100) ? 100 : int'(cfg_bw_pct);
        w = (cfg_bw_win == 0) ? 1 : int'(cfg_bw_win);
        return (p * w) / 100;
    endfunction

    always @(posedge clk) if (mon_en) cyc <= cyc + 1;

    // Scoreboard: outputs after edge cyc, then ready and acceptance for edge cyc+1.
    always @(negedge clk) begin
        if (mon_en) begin
            bit exp_rv;
            bit exp_wa;
            bit thr_ok;
            bit rd_ok;
            bit wr_ok;
            bit tot_ok;
            bit exp_rdy;
            bit acc;
            int win_eff;
            string tag;

            exp_rv = (rq_due.size() > 0) && (rq_due[0] == cyc);
            check(rd_valid == exp_rv, lat_tag, "rd_valid", DW'(rd_valid), DW'(exp_rv));
            if (exp_rv) begin
                if (rd_valid) check(rd_data == rq_data[0], "R3", "rd_data", rd_data, rq_data[0]);
                void'(rq_due.pop_front());
                void'(rq_data.pop_front());
            end

            exp_wa = (wq_due.size() > 0) && (wq_due[0] == cyc);
            check(wr_ack == exp_wa, (lat_tag == "R4") ? "R4" : "R2", "wr_ack", DW'(wr_ack), DW'(exp_wa));
            if (exp_wa) begin
                if (wr_ack) check(wr_ack_addr == wq_addr[0], "R2", "wr_ack_addr",
                                  DW'(wr_ack_addr), DW'(wq_addr[0]));
                void'(wq_due.pop_front());
                void'(wq_addr.pop_front());
            end

            thr_ok  = m_beats < exp_quota();
            rd_ok   = rq_due.size() < eff_cap(int'(cfg_rd_cap));
            wr_ok   = wq_due.size() < eff_cap(int'(cfg_wr_cap));
            tot_ok  = (rq_due.size() + wq_due.size()) < int'(cfg_tot_cap);
            exp_rdy = thr_ok && tot_ok && (req_write ? wr_ok : rd_ok);
            if (!thr_ok) tag = thr_tag;
            else if (!tot_ok) tag = "R7";
            else if (req_write && !wr_ok) tag = "R6";
            else if (!req_write && !rd_ok) tag = "R5";
            else tag = "R11";
            check(req_ready == exp_rdy, tag, "req_ready", DW'(req_ready), DW'(exp_rdy));

            acc = req_valid && exp_rdy;
            if (acc) begin
                if (req_write) begin
                    wq_due.push_back(cyc + 1 + eff_lat(int'(cfg_wr_lat)));
                    wq_addr.push_back(req_addr);
                    mem_m[req_addr] = req_wdata;
                end else begin
                    rq_due.push_back(cyc + 1 + eff_lat(int'(cfg_rd_lat)));
                    rq_data.push_back(mem_m[req_addr]);
                end
            end

            win_eff = (cfg_bw_win == 0) ? 1 : int'(cfg_bw_win);
            if (m_pos >= win_eff - 1) begin
                m_pos   = 0;
                m_beats = 0;
            end else begin
                m_pos   = m_pos + 1;
                m_beats = m_beats + (acc ? 1 : 0);
            end
        end
    end

    task automatic set_cfg(input int rl, input int wl, input int rc, input int wc,
                           input int tc, input int pct, input int win);
        @(posedge clk);
        #1;
        cfg_rd_lat  = LATW'(rl);
        cfg_wr_lat  = LATW'(wl);
        cfg_rd_cap  = CNTW'(rc);
        cfg_wr_cap  = CNTW'(wc);
        cfg_tot_cap = TOTW'(tc);
        cfg_bw_pct  = PCTW'(pct);
        cfg_bw_win  = WINW'(win);
    endtask

    task automatic drain();
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (rq_due.size() == 0 && wq_due.size() == 0) break;
            @(posedge clk);
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic issue(input bit wr, input int addr, input logic [DW-1:0] d);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = d;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic traffic(input int ncyc, input int dens, input int wr_pct);
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            #1;
            req_valid = ($urandom_range(99) < dens);
            req_write = ($urandom_range(99) < wr_pct);
            req_addr  = AW'($urandom_range((1 << AW) - 1));
            req_wdata = {$urandom, $urandom, $urandom, $urandom};
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        cfg_rd_lat = 11'd180; cfg_wr_lat = 11'd30;
        cfg_rd_cap = 8'd128;  cfg_wr_cap = 8'd128; cfg_tot_cap = 9'd128;
        cfg_bw_pct = 7'd50;   cfg_bw_win = 16'd100;

        // R10: quiet outputs while reset is held.
        repeat (3) begin
            @(negedge clk);
            check(!rd_valid, "R10", "rd_valid in reset", DW'(rd_valid), '0);
            check(!wr_ack, "R10", "wr_ack in reset", DW'(wr_ack), '0);
            check(rd_data == '0, "R10", "rd_data in reset", rd_data, '0);
        end
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "req_ready after reset", DW'(req_ready), DW'(1));

        // Directed: snapshot semantics, never-written word reads zero (R3).
        set_cfg(5, 3, 128, 128, 256, 100, 1);
        issue(1'b1, 5, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666);
        issue(1'b0, 5, '0);
        issue(1'b0, 7, '0);
        issue(1'b1, 5, 128'h0123_4567_89AB_CDEF_0F0F_F0F0_1234_5678);
        issue(1'b0, 5, '0);
        drain();

        // R4: latency clamps at both ends.
        lat_tag = "R4";
        set_cfg(0, 0, 128, 128, 256, 100, 1);
        issue(1'b1, 9, 128'h99);
        issue(1'b0, 9, '0);
        drain();
        set_cfg(1500, 2047, 128, 128, 256, 100, 1);
        issue(1'b0, 9, '0);
        issue(1'b1, 10, 128'h77);
        drain();
        lat_tag = "R1";

        // R5 R6 R7: small caps under full-rate traffic.
        set_cfg(40, 40, 3, 2, 4, 100, 1);
        traffic(300, 100, 50);
        drain();
        set_cfg(20, 20, 0, 5, 200, 100, 1);
        traffic(100, 100, 30);
        drain();
        // R5: cap above the queue depth acts as the depth.
        set_cfg(300, 10, 200, 128, 511, 100, 1);
        traffic(250, 100, 0);
        drain();

        // R8: suggested settings, then a short window.
        set_cfg(180, 30, 128, 128, 128, 50, 100);
        traffic(1500, 90, 40);
        drain();
        set_cfg(12, 8, 128, 128, 128, 30, 10);
        traffic(600, 80, 50);
        drain();

        // R9: percentage 0 blocks; over-range percentage and zero window clamp.
        thr_tag = "R9";
        set_cfg(6, 6, 128, 128, 128, 0, 7);
        traffic(150, 100, 50);
        drain();
        set_cfg(6, 6, 128, 128, 128, 127, 0);
        traffic(200, 100, 50);
        drain();
        thr_tag = "R8";

        // Random configurations mixed with random traffic (R1 R2 R3 R11).
        for (int k = 0; k < 6; k++) begin
            set_cfg($urandom_range(60, 1), $urandom_range(60, 0), $urandom_range(10, 1),
                    $urandom_range(10, 1), $urandom_range(16, 1), $urandom_range(100, 20),
                    $urandom_range(30, 0));
            traffic(800, 70, 40);
            drain();
        end

        check(rq_due.size() == 0, "R1", "reads left over", DW'(rq_due.size()), '0);
        check(wq_due.size() == 0, "R2", "acks left over", DW'(wq_due.size()), '0);
        finish_run();
    end
endmodule